// File: doc/BRIEF.md
# SPI Clock Prescaler Search Engine

This block picks the clock-divider setting for an SPI controller whose serial clock is derived from a core clock through two cascaded stages: a power-of-two prescaler selected by a 3-bit exponent, and a 4-bit integer mantissa. Given the core clock frequency and the serial speed that is wanted, it tries all eight exponents in turn. It finds the setting whose resulting serial speed comes closest to the request without exceeding it.

The search runs as a sequential engine. A one-cycle `start` latches the two 32-bit inputs and raises `busy`. For each exponent the engine first divides the prescaled clock by the request to get a rounded-up mantissa. If that mantissa is usable, a second division gives the speed that the setting actually produces. Both divisions share one restoring divider that yields one quotient bit per cycle. When the search ends, `done` pulses for one cycle. At that point either `ok` is high and the packed 8-bit setting is on `setting`, or `err` is high and no setting is produced.

Top module: `spi_baud_search`

## Requirements
- R1: After reset, `busy`, `done`, `ok` and `err` are low and `setting` is zero.
- R2: A `start` while idle with nonzero speed raises `busy` on the next cycle. When the search ends, `done` is high for exactly one cycle, and `busy` falls in that same cycle.
- R3: A `start` while idle with a requested speed of zero gives `done` and `err` on the next cycle, with `ok` low and `setting` zero.
- R4: For each exponent e from 0 to 7, the mantissa is m = ceil(floor(fclk / 2^e) / speed). An exponent whose m is 0 or above 15 is not a candidate.
- R5: A candidate produces the actual speed floor(fclk / (m * 2^e)), and its error is speed minus that actual speed. The result is the candidate with the smallest error. The error bound starts at the requested speed, and a candidate wins only with a strictly smaller error, so on equal error the lower exponent is kept.
- R6: When no candidate wins, `err` is high, `ok` is low and `setting` is zero at `done`.
- R7: When `ok` is high, `setting` = {e[2:1], 1'b0, e[0], m[3:0]}. Bits 7:6 hold the upper exponent bits, bit 5 is always 0, bit 4 holds the exponent LSB, and bits 3:0 hold the mantissa.
- R8: A `start` that arrives while `busy` is high is ignored. The running search finishes with the result for the inputs it latched, and no extra `done` follows.
- R9: `ok` and `err` are never both high, and `setting`, `ok` and `err` change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search; sampled only while idle |
| fclk_hz | input | 32 | Core clock frequency, unsigned |
| speed_hz | input | 32 | Requested SPI speed, unsigned |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse at the end of a search |
| ok | output | 1 | Last search found a setting |
| err | output | 1 | Last search found no setting |
| setting | output | 8 | Packed exponent and mantissa field |

## Verification
An internal fault shows up at the ports only when `done` fires. There are several ways it can appear. A wrong exponent loop count or skip test moves the chosen setting to a different exponent. A comparison that is not strict breaks ties toward the higher exponent. A divider that is off by one changes the mantissa, or turns a valid request into an error. A fault in the `busy` guard shows as a second `done` or as a result for the wrong inputs. All of these appear within one search, which takes at most about 550 cycles. The stimulus therefore pairs random clock and speed values with requests built as exact ratios, which produce ties. It also targets the mantissa limit of 15 and the cases where nothing fits.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
    localparam int NUM_EXP   = 8;
    localparam int EXP_W     = $clog2(NUM_EXP);
    localparam int MANT_W    = 4;
    localparam int MANT_MAX  = (1 << MANT_W) - 1;
    localparam int FIELD_W   = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MANT,
        ST_RATE
    } search_st_e;
endpackage

// File: rtl/spi_baud_divider.sv
module spi_baud_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         fin,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic         run;
        logic         fin;
        logic [CW-1:0] cnt;
        logic [W-1:0] rem;
        logic [W-1:0] quo;
        logic [W-1:0] den;
    } div_s;

    div_s r_q, r_d;
    logic [W:0] trial;

    always_comb begin
        r_d     = r_q;
        r_d.fin = 1'b0;
        trial   = {r_q.rem, r_q.quo[W-1]};
        if (go) begin
            r_d.run = 1'b1;
            r_d.cnt = CW'(W);
            r_d.rem = '0;
            r_d.quo = num;
            r_d.den = den;
        end else if (r_q.run) begin
            if (trial >= {1'b0, r_q.den}) begin
                r_d.rem = W'(trial - {1'b0, r_q.den});
                r_d.quo = {r_q.quo[W-2:0], 1'b1};
            end else begin
                r_d.rem = trial[W-1:0];
                r_d.quo = {r_q.quo[W-2:0], 1'b0};
            end
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CW'(1)) begin
                r_d.run = 1'b0;
                r_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign fin = r_q.fin;
    assign quo = r_q.quo;
    assign rem = r_q.rem;
endmodule

// File: rtl/spi_baud_pack.sv
module spi_baud_pack
    import spi_baud_pkg::*;
(
    input  logic [EXP_W-1:0]   exp_sel,
    input  logic [MANT_W-1:0]  mant,
    output logic [FIELD_W-1:0] field
);
    // Split layout: exponent high bits at the top, a hole at bit 5,
    // exponent LSB at bit 4, mantissa in the low nibble.
    assign field = {exp_sel[2:1], 1'b0, exp_sel[0], mant};
endmodule

// File: rtl/spi_baud_search.sv
module spi_baud_search
    import spi_baud_pkg::*;
#(
    parameter int W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [W-1:0]       fclk_hz,
    input  logic [W-1:0]       speed_hz,
    output logic               busy,
    output logic               done,
    output logic               ok,
    output logic               err,
    output logic [FIELD_W-1:0] setting
);
    localparam logic [EXP_W-1:0] EXP_LAST = EXP_W'(NUM_EXP - 1);

    typedef struct packed {
        search_st_e          st;
        logic [EXP_W-1:0]    exp_cur;
        logic [MANT_W-1:0]   mant_cur;
        logic [W-1:0]        fclk;
        logic [W-1:0]        speed;
        logic [W-1:0]        best_err;
        logic [MANT_W-1:0]   best_mant;
        logic [EXP_W-1:0]    best_exp;
        logic                go;
        logic [W-1:0]        num;
        logic [W-1:0]        den;
        logic                done;
        logic                ok;
        logic                err;
        logic [FIELD_W-1:0]  field;
    } srch_s;

    srch_s r_q, r_d;

    logic         dv_fin;
    logic [W-1:0] dv_quo;
    logic [W-1:0] dv_rem;

    spi_baud_divider #(.W(W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (r_q.go),
        .num   (r_q.num),
        .den   (r_q.den),
        .fin   (dv_fin),
        .quo   (dv_quo),
        .rem   (dv_rem)
    );

    // Candidate evaluation, kept apart from the state update so the
    // packer sees the final winner without a loop through r_d.
    logic                rem_nz;
    logic                mant_skip;
    logic [MANT_W-1:0]   mant_ceil;
    logic [W-1:0]        cand_err;
    logic                take;
    logic [MANT_W-1:0]   win_mant;
    logic [EXP_W-1:0]    win_exp;
    logic [FIELD_W-1:0]  win_field;

    always_comb begin
        rem_nz    = (dv_rem != '0);
        mant_skip = ((dv_quo == '0) && !rem_nz)
                  || (dv_quo > W'(MANT_MAX))
                  || ((dv_quo == W'(MANT_MAX)) && rem_nz);
        mant_ceil = dv_quo[MANT_W-1:0] + MANT_W'(rem_nz);
        cand_err  = r_q.speed - dv_quo;
        take      = (r_q.st == ST_RATE) && dv_fin && (cand_err < r_q.best_err);
        win_mant  = take ? r_q.mant_cur : r_q.best_mant;
        win_exp   = take ? r_q.exp_cur  : r_q.best_exp;
    end

    spi_baud_pack u_pack (
        .exp_sel (win_exp),
        .mant    (win_mant),
        .field   (win_field)
    );

    always_comb begin
        logic step;
        logic found;
        r_d      = r_q;
        r_d.go   = 1'b0;
        r_d.done = 1'b0;
        step     = 1'b0;
        found    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (speed_hz == '0) begin
                        r_d.done  = 1'b1;
                        r_d.ok    = 1'b0;
                        r_d.err   = 1'b1;
                        r_d.field = '0;
                    end else begin
                        r_d.fclk      = fclk_hz;
                        r_d.speed     = speed_hz;
                        r_d.exp_cur   = '0;
                        r_d.best_err  = speed_hz;
                        r_d.best_mant = '0;
                        r_d.best_exp  = '0;
                        r_d.go        = 1'b1;
                        r_d.num       = fclk_hz;
                        r_d.den       = speed_hz;
                        r_d.st        = ST_MANT;
                    end
                end
            end
            ST_MANT: begin
                if (dv_fin) begin
                    if (mant_skip) begin
                        step = 1'b1;
                    end else begin
                        r_d.mant_cur = mant_ceil;
                        r_d.go       = 1'b1;
                        r_d.num      = r_q.fclk;
                        r_d.den      = W'(mant_ceil) << r_q.exp_cur;
                        r_d.st       = ST_RATE;
                    end
                end
            end
            ST_RATE: begin
                if (dv_fin) begin
                    if (take) begin
                        r_d.best_err  = cand_err;
                        r_d.best_mant = r_q.mant_cur;
                        r_d.best_exp  = r_q.exp_cur;
                    end
                    step = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (step) begin
            if (r_q.exp_cur == EXP_LAST) begin
                found     = (win_mant != '0);
                r_d.done  = 1'b1;
                r_d.ok    = found;
                r_d.err   = !found;
                r_d.field = found ? win_field : '0;
                r_d.st    = ST_IDLE;
            end else begin
                r_d.exp_cur = r_q.exp_cur + 1'b1;
                r_d.go      = 1'b1;
                r_d.num     = r_q.fclk >> (r_q.exp_cur + 1'b1);
                r_d.den     = r_q.speed;
                r_d.st      = ST_MANT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign ok      = r_q.ok;
    assign err     = r_q.err;
    assign setting = r_q.field;
endmodule

// File: rtl/spi_baud_search_chk.sv
module spi_baud_search_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] speed_hz,
    input logic         busy,
    input logic         done,
    input logic         ok,
    input logic         err,
    input logic [7:0]   setting
);
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_clear_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_start_raises_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && speed_hz != '0) |=> busy);

    assert_zero_speed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && speed_hz == '0) |=> (done && err && !ok));

    assert_fail_clears_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (setting == 8'h00));

    assert_mant_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (setting[3:0] != 4'h0 && !setting[5]));

    assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy || done));

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok && err));

    assert_result_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(setting) || !$stable(ok) || !$stable(err)) |-> done);
endmodule

bind spi_baud_search spi_baud_search_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .speed_hz (speed_hz),
    .busy     (busy),
    .done     (done),
    .ok       (ok),
    .err      (err),
    .setting  (setting)
);

// File: tb/tb_spi_baud_search.sv
module tb_spi_baud_search;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] fclk_hz = '0;
    logic [31:0] speed_hz = '0;
    logic        busy, done, ok, err;
    logic [7:0]  setting;

    int checks = 0;
    int fails  = 0;
    bit timed_out = 1'b0;

    always #2 clk = ~clk;

    spi_baud_search dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .fclk_hz(fclk_hz), .speed_hz(speed_hz),
        .busy(busy), .done(done), .ok(ok), .err(err), .setting(setting)
    );

    // Reference model: returns {ok, err, setting}
    function automatic logic [9:0] ref_calc(input logic [31:0] f, input logic [31:0] s);
        longint unsigned best_err, sc, q, m, act, e_err;
        logic [3:0] bm;
        logic [2:0] be;
        if (s == 0) return {1'b0, 1'b1, 8'h00};
        best_err = s;
        bm = 0;
        be = 0;
        for (int e = 0; e < 8; e++) begin
            sc = longint'(f) >> e;
            q  = sc / s;
            m  = q + ((sc % s) != 0 ? 1 : 0);
            if (m == 0 || m > 15) continue;
            act   = longint'(f) / (m << e);
            e_err = s - act;
            if (e_err < best_err) begin
                best_err = e_err;
                bm = m[3:0];
                be = 3'(e);
            end
        end
        if (bm == 0) return {1'b0, 1'b1, 8'h00};
        return {1'b1, 1'b0, be[2:1], 1'b0, be[0], bm};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(output int cycles);
        cycles = 0;
        while (done !== 1'b1 && cycles < 2000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic run(input logic [31:0] f, input logic [31:0] s, input string tag);
        logic [9:0] exp_v;
        int cyc;
        exp_v = ref_calc(f, s);
        @(negedge clk);
        fclk_hz = f; speed_hz = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (s != 0) check({tag, " R2 busy after start"}, {31'b0, busy}, 32'd1);
        wait_done(cyc);
        check({tag, " R2 done seen"}, {31'b0, done}, 32'd1);
        check({tag, " R2 busy low at done"}, {31'b0, busy}, 32'd0);
        check({tag, " R4 R5 R7 setting"}, {24'b0, setting}, {24'b0, exp_v[7:0]});
        check({tag, " R6 ok/err"}, {30'b0, ok, err}, {30'b0, exp_v[9:8]});
        @(negedge clk);
        check({tag, " R2 done one cycle"}, {31'b0, done}, 32'd0);
    endtask

    initial begin
        int cyc;
        logic [9:0] exp_v;
        logic [31:0] f, s, dv;
        void'($urandom(32'h5A17_C0DE));
        repeat (3) @(negedge clk);
        check("R1 reset busy", {31'b0, busy}, 32'd0);
        check("R1 reset done", {31'b0, done}, 32'd0);
        check("R1 reset flags", {30'b0, ok, err}, 32'd0);
        check("R1 reset setting", {24'b0, setting}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: zero speed rejected in one cycle
        fclk_hz = 32'd1000; speed_hz = 32'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R3 done next cycle", {31'b0, done}, 32'd1);
        check("R3 err flag", {30'b0, ok, err}, 32'd1);
        check("R3 setting zero", {24'b0, setting}, 32'd0);

        // R5 tie: exponent 0 and 1 both exact, lower must win -> 0x04
        run(32'd100, 32'd25, "tie");
        check("R5 tie lower exponent", {24'b0, setting}, 32'h04);
        // R4/R7: only exponent 6 and 7 fit; 6 wins with mantissa 15 -> 0xCF
        run(32'd1000, 32'd1, "limit");
        check("R7 packed field", {24'b0, setting}, 32'hCF);
        // R6: nothing fits
        run(32'd1_000_000, 32'd1, "toolow");
        check("R6 no setting err", {31'b0, err}, 32'd1);
        run(32'd0, 32'd5, "zeroclk");
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, "maxio");
        run(32'd200_000_000, 32'd50_000_000, "fast");
        run(32'd166_000_000, 32'd1_000_000, "mid");
        run(32'd5, 32'd100, "overspeed");

        // R8: start while busy is ignored
        @(negedge clk);
        fclk_hz = 32'd250_000_000; speed_hz = 32'd3_000_000; start = 1'b1;
        exp_v = ref_calc(32'd250_000_000, 32'd3_000_000);
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        fclk_hz = 32'd7; speed_hz = 32'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; fclk_hz = 32'd9; speed_hz = 32'd1;
        check("R8 still busy", {31'b0, busy}, 32'd1);
        wait_done(cyc);
        check("R8 result of first request", {22'b0, ok, err, setting}, {22'b0, exp_v});
        @(negedge clk);
        repeat (40) begin
            check("R8 no second done", {31'b0, done}, 32'd0);
            @(negedge clk);
        end

        // Random mix
        for (int i = 0; i < 120; i++) begin
            f  = $urandom();
            dv = ($urandom() % 2500) + 1;
            if (i % 3 == 0) s = $urandom();
            else if (i % 3 == 1) s = f / dv;
            else s = (f / dv) + ($urandom() % 64);
            if (s == 0) s = 1;
            run(f, s, "rand R4 R5");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
        checks++;
        fails++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule